// File: doc/BRIEF.md
# Indexed CMOS RAM Port Bridge

This block sits on a small host I/O bus and gives index/data access to a 256-byte CMOS RAM through three port pairs. Each pair has an index port, where software writes the location it wants, and a data port, where it reads or writes the byte at that location. The bridge keeps a separate index latch for each pair. It routes each data access either to the on-chip RAM, through a narrow read/write interface, or to an external real-time-clock bus.

The legacy pair stores an NMI mask bit in the top bit of its index register. As a result it can reach only the lower half of the RAM, and the mask bit gates two error inputs into a non-maskable interrupt output. The second pair uses a full 8-bit index. Both of these pairs follow a select input that chooses the on-chip RAM or the external clock device. The third pair also uses a full 8-bit index and always targets the on-chip RAM. It works only when two enable inputs are both set, so the RAM stays reachable even when the on-chip clock is not selected.

Top module: `cmos_port_bridge`

## Requirements
- R1: After reset the NMI mask bit is 1, all three index latches are 0, `io_rdata` is 0 and `nmi_out` is 0.
- R2: Port codes are: 0 index A, 1 data A, 2 index B, 3 data B, 4 index C, 5 data C. A write to port 0 stores `io_wdata[7]` as the NMI mask and `io_wdata[6:0]` as index A. A read of port 0 returns `{mask, indexA}`.
- R3: `nmi_out` is registered. One cycle after any cycle, it equals `!mask && (err_chan || err_sys)`.
- R4: When `cfg_int_rtc` is 1, a data A access drives the RAM interface in the same cycle with address `{1'b0, indexA}`.
- R5: Index B is a full 8 bits and reads back on port 2. When `cfg_int_rtc` is 1, a data B access uses it as the RAM address.
- R6: When `cfg_int_rtc` is 0, data A and data B accesses go to the external port instead of the RAM. The external port receives the index, the write data and a read or write strobe, and a read returns `ext_rdata`.
- R7: When `cfg_sram_en` and `cfg_pc_en` are both 1, pair C reaches the RAM with its 8-bit index, whatever the value of `cfg_int_rtc`.
- R8: When pair C is not enabled, reads of ports 4 and 5 return 0xFF. Writes to them change neither index C nor any memory.
- R9: Data accesses never change the index. Repeated data accesses on a pair hit the same location.
- R10: A read loads `io_rdata` one cycle after `io_rd`, and `io_rdata` holds at all other times. Ports 6 and 7 read 0xFF and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_rd | input | 1 | Host read strobe (one cycle) |
| io_wr | input | 1 | Host write strobe (one cycle) |
| io_port | input | 3 | Port select |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Registered host read data |
| cfg_int_rtc | input | 1 | 1 selects the on-chip RAM for pairs A and B |
| cfg_sram_en | input | 1 | On-chip RAM enable for pair C |
| cfg_pc_en | input | 1 | Pair C access enable |
| err_chan | input | 1 | Bus channel-check error |
| err_sys | input | 1 | System error |
| nmi_out | output | 1 | Gated NMI request |
| ram_addr | output | 8 | RAM address |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data (combinational) |
| ext_addr | output | 8 | External RTC index |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_wdata | output | 8 | External write data |
| ext_rdata | input | 8 | External read data (combinational) |

## Verification
RAM and external strobes, addresses and write data follow the host strobe in the same cycle, so the bench models both memories and checks that they were committed on the clock edge that ends the strobe. An index write takes effect at that edge. `io_rdata` appears one edge after the read strobe, and the bench samples it on the falling edge that follows. `nmi_out` lags the mask and error inputs by one edge, and the bench reads it one full cycle after changing them.

// File: rtl/cmos_bridge_pkg.sv
package cmos_bridge_pkg;
  localparam int DW     = 8;
  localparam int AW     = 8;
  localparam int NPAIR  = 3;
  localparam int PSW    = 3;
  localparam int LEGW   = AW - 1;

  typedef enum logic [1:0] {
    PAIR_A    = 2'd0,
    PAIR_B    = 2'd1,
    PAIR_C    = 2'd2,
    PAIR_NONE = 2'd3
  } pair_e;

  // Port code to pair: codes 0..5 map to pairs, 6..7 map to none.
  function automatic pair_e pair_of(input logic [PSW-1:0] port);
    case (port[PSW-1:1])
      2'd0:    pair_of = PAIR_A;
      2'd1:    pair_of = PAIR_B;
      2'd2:    pair_of = PAIR_C;
      default: pair_of = PAIR_NONE;
    endcase
  endfunction

  function automatic logic is_data_port(input logic [PSW-1:0] port);
    is_data_port = port[0];
  endfunction

  // Legacy pair reaches only the lower half of the array.
  function automatic logic [AW-1:0] legacy_addr(input logic [LEGW-1:0] idx);
    legacy_addr = {1'b0, idx};
  endfunction

  function automatic logic nmi_gate(input logic mask, input logic e1, input logic e2);
    nmi_gate = !mask && (e1 || e2);
  endfunction
endpackage

// File: rtl/cmos_index_bank.sv
module cmos_index_bank
  import cmos_bridge_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      idx_we,
  input  pair_e                     idx_pair,
  input  logic [DW-1:0]             wdata,
  output logic                      nmi_mask,
  output logic [NPAIR-1:0][AW-1:0]  idx_q
);
  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    logic hit;
    assign hit = idx_we && (idx_pair == pair_e'(g));
    if (g == 0) begin : g_legacy
      always_ff @(posedge clk) begin
        if (!rst_n)   idx_q[g] <= '0;
        else if (hit) idx_q[g] <= legacy_addr(wdata[LEGW-1:0]);
      end
    end else begin : g_full
      always_ff @(posedge clk) begin
        if (!rst_n)   idx_q[g] <= '0;
        else if (hit) idx_q[g] <= wdata[AW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      nmi_mask <= 1'b1;
    else if (idx_we && idx_pair == PAIR_A)
      nmi_mask <= wdata[DW-1];
  end
endmodule

// File: rtl/cmos_access_route.sv
module cmos_access_route
  import cmos_bridge_pkg::*;
(
  input  logic                      io_rd,
  input  logic                      io_wr,
  input  pair_e                     pair,
  input  logic                      is_data,
  input  logic                      int_rtc,
  input  logic                      c_open,
  input  logic                      nmi_mask,
  input  logic [NPAIR-1:0][AW-1:0]  idx_q,
  input  logic [DW-1:0]             wdata,
  input  logic [DW-1:0]             ram_rdata,
  input  logic [DW-1:0]             ext_rdata,
  output logic [AW-1:0]             ram_addr,
  output logic                      ram_rd,
  output logic                      ram_wr,
  output logic [DW-1:0]             ram_wdata,
  output logic [AW-1:0]             ext_addr,
  output logic                      ext_rd,
  output logic                      ext_wr,
  output logic [DW-1:0]             ext_wdata,
  output logic [DW-1:0]             rd_value,
  output logic                      to_ram,
  output logic                      to_ext
);
  logic [AW-1:0] sel_idx;

  always_comb begin
    sel_idx = '0;
    to_ram  = 1'b0;
    to_ext  = 1'b0;
    case (pair)
      PAIR_A: begin
        sel_idx = idx_q[0];
        to_ram  = is_data && int_rtc;
        to_ext  = is_data && !int_rtc;
      end
      PAIR_B: begin
        sel_idx = idx_q[1];
        to_ram  = is_data && int_rtc;
        to_ext  = is_data && !int_rtc;
      end
      PAIR_C: begin
        sel_idx = idx_q[2];
        to_ram  = is_data && c_open;
      end
      default: sel_idx = '0;
    endcase
  end

  assign ram_addr  = sel_idx;
  assign ram_rd    = to_ram && io_rd;
  assign ram_wr    = to_ram && io_wr;
  assign ram_wdata = wdata;
  assign ext_addr  = sel_idx;
  assign ext_rd    = to_ext && io_rd;
  assign ext_wr    = to_ext && io_wr;
  assign ext_wdata = wdata;

  always_comb begin
    rd_value = '1;
    if (is_data) begin
      if (to_ram)      rd_value = ram_rdata;
      else if (to_ext) rd_value = ext_rdata;
    end else begin
      case (pair)
        PAIR_A:  rd_value = {nmi_mask, idx_q[0][LEGW-1:0]};
        PAIR_B:  rd_value = idx_q[1];
        PAIR_C:  rd_value = c_open ? idx_q[2] : '1;
        default: rd_value = '1;
      endcase
    end
  end
endmodule

// File: rtl/cmos_nmi_gate.sv
module cmos_nmi_gate
  import cmos_bridge_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_mask,
  input  logic err_chan,
  input  logic err_sys,
  output logic nmi_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) nmi_out <= 1'b0;
    else        nmi_out <= nmi_gate(nmi_mask, err_chan, err_sys);
  end
endmodule

// File: rtl/cmos_port_bridge.sv
module cmos_port_bridge
  import cmos_bridge_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            io_rd,
  input  logic            io_wr,
  input  logic [2:0]      io_port,
  input  logic [7:0]      io_wdata,
  output logic [7:0]      io_rdata,
  input  logic            cfg_int_rtc,
  input  logic            cfg_sram_en,
  input  logic            cfg_pc_en,
  input  logic            err_chan,
  input  logic            err_sys,
  output logic            nmi_out,
  output logic [7:0]      ram_addr,
  output logic            ram_rd,
  output logic            ram_wr,
  output logic [7:0]      ram_wdata,
  input  logic [7:0]      ram_rdata,
  output logic [7:0]      ext_addr,
  output logic            ext_rd,
  output logic            ext_wr,
  output logic [7:0]      ext_wdata,
  input  logic [7:0]      ext_rdata
);
  pair_e                     pair;
  logic                      is_data;
  logic                      c_open;
  logic                      idx_we;
  logic                      nmi_mask;
  logic [NPAIR-1:0][AW-1:0]  idx_q;
  logic [DW-1:0]             rd_value;
  logic                      to_ram;
  logic                      to_ext;

  assign pair    = pair_of(io_port);
  assign is_data = is_data_port(io_port);
  assign c_open  = cfg_sram_en && cfg_pc_en;
  assign idx_we  = io_wr && !is_data && (pair != PAIR_NONE) &&
                   ((pair != PAIR_C) || c_open);

  cmos_index_bank u_idx (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_we   (idx_we),
    .idx_pair (pair),
    .wdata    (io_wdata),
    .nmi_mask (nmi_mask),
    .idx_q    (idx_q)
  );

  cmos_access_route u_route (
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .pair      (pair),
    .is_data   (is_data),
    .int_rtc   (cfg_int_rtc),
    .c_open    (c_open),
    .nmi_mask  (nmi_mask),
    .idx_q     (idx_q),
    .wdata     (io_wdata),
    .ram_rdata (ram_rdata),
    .ext_rdata (ext_rdata),
    .ram_addr  (ram_addr),
    .ram_rd    (ram_rd),
    .ram_wr    (ram_wr),
    .ram_wdata (ram_wdata),
    .ext_addr  (ext_addr),
    .ext_rd    (ext_rd),
    .ext_wr    (ext_wr),
    .ext_wdata (ext_wdata),
    .rd_value  (rd_value),
    .to_ram    (to_ram),
    .to_ext    (to_ext)
  );

  cmos_nmi_gate u_nmi (
    .clk      (clk),
    .rst_n    (rst_n),
    .nmi_mask (nmi_mask),
    .err_chan (err_chan),
    .err_sys  (err_sys),
    .nmi_out  (nmi_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     io_rdata <= '0;
    else if (io_rd) io_rdata <= rd_value;
  end
endmodule

// File: rtl/cmos_port_bridge_chk.sv
module cmos_port_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       io_rd,
  input logic       io_wr,
  input logic [2:0] io_port,
  input logic       cfg_int_rtc,
  input logic       cfg_sram_en,
  input logic       cfg_pc_en,
  input logic       err_chan,
  input logic       err_sys,
  input logic       nmi_mask,
  input logic       nmi_out,
  input logic       ram_rd,
  input logic       ram_wr,
  input logic [7:0] ram_addr,
  input logic       ext_rd,
  input logic       ext_wr,
  input logic [7:0] io_rdata,
  input logic       to_ram,
  input logic       to_ext
);
  p_nmi_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_mask && (err_chan || err_sys)) |=> nmi_out);

  p_nmi_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_mask |=> !nmi_out);

  p_legacy_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_port == 3'd1 && cfg_int_rtc) |-> (ram_rd && !ram_addr[7]));

  p_ext_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_port == 3'd3 && !cfg_int_rtc) |-> (ext_wr && !ram_wr));

  p_pc_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_port == 3'd5 && !(cfg_sram_en && cfg_pc_en)) |-> (!ram_wr && !ext_wr));

  p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(to_ram && to_ext));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));

  p_strobe_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_rd, ram_wr, ext_rd, ext_wr}));
endmodule

bind cmos_port_bridge cmos_port_bridge_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .io_rd       (io_rd),
  .io_wr       (io_wr),
  .io_port     (io_port),
  .cfg_int_rtc (cfg_int_rtc),
  .cfg_sram_en (cfg_sram_en),
  .cfg_pc_en   (cfg_pc_en),
  .err_chan    (err_chan),
  .err_sys     (err_sys),
  .nmi_mask    (nmi_mask),
  .nmi_out     (nmi_out),
  .ram_rd      (ram_rd),
  .ram_wr      (ram_wr),
  .ram_addr    (ram_addr),
  .ext_rd      (ext_rd),
  .ext_wr      (ext_wr),
  .io_rdata    (io_rdata),
  .to_ram      (to_ram),
  .to_ext      (to_ext)
);

// File: tb/tb_cmos_port_bridge.sv
module tb_cmos_port_bridge;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_rd = 1'b0, io_wr = 1'b0;
  logic [2:0] io_port = '0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic       cfg_int_rtc = 1'b1, cfg_sram_en = 1'b0, cfg_pc_en = 1'b0;
  logic       err_chan = 1'b0, err_sys = 1'b0;
  logic       nmi_out;
  logic [7:0] ram_addr, ram_wdata, ram_rdata;
  logic       ram_rd, ram_wr;
  logic [7:0] ext_addr, ext_wdata, ext_rdata;
  logic       ext_rd, ext_wr;

  logic [7:0] ram_mem [256];
  logic [7:0] ext_mem [256];

  int n_chk = 0, n_bad = 0;
  logic       m_mask;
  logic [6:0] m_ia;
  logic [7:0] m_ib, m_ic;
  logic [7:0] m_ram [256];
  logic [7:0] m_ext [256];

  always #10 clk = ~clk;

  cmos_port_bridge dut (.*);

  assign ram_rdata = ram_mem[ram_addr];
  assign ext_rdata = ext_mem[ext_addr];
  always @(posedge clk) begin
    if (ram_wr) ram_mem[ram_addr] <= ram_wdata;
    if (ext_wr) ext_mem[ext_addr] <= ext_wdata;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic c_en();
    return cfg_sram_en && cfg_pc_en;
  endfunction

  function automatic logic [7:0] exp_read(input logic [2:0] p);
    case (p)
      3'd0: return {m_mask, m_ia};
      3'd1: return cfg_int_rtc ? m_ram[{1'b0, m_ia}] : m_ext[{1'b0, m_ia}];
      3'd2: return m_ib;
      3'd3: return cfg_int_rtc ? m_ram[m_ib] : m_ext[m_ib];
      3'd4: return c_en() ? m_ic : 8'hFF;
      3'd5: return c_en() ? m_ram[m_ic] : 8'hFF;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic model_write(input logic [2:0] p, input logic [7:0] d);
    case (p)
      3'd0: begin m_mask = d[7]; m_ia = d[6:0]; end
      3'd1: if (cfg_int_rtc) m_ram[{1'b0, m_ia}] = d; else m_ext[{1'b0, m_ia}] = d;
      3'd2: m_ib = d;
      3'd3: if (cfg_int_rtc) m_ram[m_ib] = d; else m_ext[m_ib] = d;
      3'd4: if (c_en()) m_ic = d;
      3'd5: if (c_en()) m_ram[m_ic] = d;
      default: ;
    endcase
  endtask

  task automatic wr(input logic [2:0] p, input logic [7:0] d);
    @(negedge clk);
    io_port = p; io_wdata = d; io_wr = 1'b1;
    model_write(p, d);
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] p, input string req);
    logic [7:0] e;
    @(negedge clk);
    io_port = p; io_rd = 1'b1;
    e = exp_read(p);
    @(negedge clk);
    io_rd = 1'b0;
    check(req, io_rdata, e);
  endtask

  task automatic nmi_chk(input logic c, input logic s, input string req);
    @(negedge clk);
    err_chan = c; err_sys = s;
    @(negedge clk);
    check(req, {7'd0, nmi_out}, {7'd0, !m_mask && (c || s)});
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 256; i++) begin
      ram_mem[i] = 8'(i * 7 + 3); m_ram[i] = 8'(i * 7 + 3);
      ext_mem[i] = 8'(i ^ 8'hA5); m_ext[i] = 8'(i ^ 8'hA5);
    end
    m_mask = 1'b1; m_ia = '0; m_ib = '0; m_ic = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", io_rdata, 8'h00);
    check("R1 nmi", {7'd0, nmi_out}, 8'h00);
    cfg_sram_en = 1'b1; cfg_pc_en = 1'b1;
    rd(3'd0, "R1 idxA/mask");
    rd(3'd2, "R1 idxB");
    rd(3'd4, "R1 idxC");
    nmi_chk(1'b1, 1'b1, "R3 masked at reset");
    // R2 legacy index and mask
    wr(3'd0, 8'h7F); rd(3'd0, "R2 readback");
    nmi_chk(1'b1, 1'b0, "R3 chan err");
    nmi_chk(1'b0, 1'b1, "R3 sys err");
    nmi_chk(1'b0, 1'b0, "R3 quiet");
    // R4 lower half only: index 0x7F targets RAM 0x7F
    wr(3'd1, 8'h3C); rd(3'd1, "R4 data A");
    check("R4 ram 7F", ram_mem[8'h7F], 8'h3C);
    check("R4 ram FF untouched", ram_mem[8'hFF], m_ram[8'hFF]);
    // R5 full index
    wr(3'd2, 8'hF0); rd(3'd2, "R5 idxB");
    wr(3'd3, 8'h96); check("R5 ram F0", ram_mem[8'hF0], 8'h96);
    // R9 no auto increment
    wr(3'd3, 8'h69); rd(3'd3, "R9 same loc"); rd(3'd2, "R9 idx unchanged");
    // R6 external route
    cfg_int_rtc = 1'b0;
    wr(3'd3, 8'h11); check("R6 ext F0", ext_mem[8'hF0], 8'h11);
    check("R6 ram F0 kept", ram_mem[8'hF0], 8'h69);
    rd(3'd1, "R6 ext read A");
    // R7 pair C independent of select
    wr(3'd4, 8'hC5); wr(3'd5, 8'h5A);
    check("R7 ram C5", ram_mem[8'hC5], 8'h5A); rd(3'd5, "R7 read C");
    // R8 pair C disabled
    cfg_pc_en = 1'b0;
    wr(3'd4, 8'h10); wr(3'd5, 8'hEE);
    rd(3'd4, "R8 idx read FF"); rd(3'd5, "R8 data read FF");
    check("R8 ram C5 kept", ram_mem[8'hC5], 8'h5A);
    cfg_pc_en = 1'b1; rd(3'd4, "R8 idx kept");
    cfg_sram_en = 1'b0; rd(3'd5, "R8 sram off FF"); cfg_sram_en = 1'b1;
    // R10 unused ports and hold
    wr(3'd6, 8'h00); rd(3'd7, "R10 unused FF");
    rd(3'd2, "R10 load");
    repeat (3) @(negedge clk);
    check("R10 hold", io_rdata, m_ib);
    // Random mix
    for (int i = 0; i < 1500; i++) begin
      logic [2:0] p;
      p = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 9) == 0) begin
        cfg_int_rtc = 1'($urandom); cfg_sram_en = 1'($urandom); cfg_pc_en = 1'($urandom);
      end
      if ($urandom_range(0, 1) == 1) wr(p, 8'($urandom));
      else rd(p, "R10 random read");
      if ($urandom_range(0, 7) == 0)
        nmi_chk(1'($urandom), 1'($urandom), "R3 random");
    end
    for (int i = 0; i < 256; i++) begin
      check("R7 ram image", ram_mem[i], m_ram[i]);
      check("R6 ext image", ext_mem[i], m_ext[i]);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule